// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block gathers a set of level-signalled interrupt sources and routes them to a small number of contexts, where each context is one hart running in one privilege mode. Every source carries a programmable urgency and every context has its own enable bitmap and its own urgency threshold. Each context gets one interrupt line. That line is raised whenever a pending source that the context has enabled is more urgent than the context's threshold.

Software talks to the block through a single word-wide read/write register port that uses byte addresses. A handler first reads its context's claim word. The read returns the identity of the winning source and takes that source out of the pending set. After servicing it, the handler writes the same identity back to the same word. Until that write arrives, the source is in flight and further rising edges on it are dropped. Source 0 is reserved, so an identity of 0 means "nothing to service".

Top module: `irq_ctrl_core`

## Requirements
- R1: Source 0 is reserved. Its priority word (offset 0x0), its pending bit (bit 0 of offset 0x1000) and its enable bit (bit 0 of each context's first enable word) always read 0, and writes to them are ignored.
- R2: The priority of source N (1 to NUM_SRC-1) is stored at byte offset 4*N. Only bits [2:0] are kept (values 0..7, larger is more urgent), and the upper bits read as 0.
- R3: The pending bitmap starts at offset 0x1000. Word k holds sources 32k..32k+31, with source 32k+b at bit b. The bitmap is read-only: a write to it changes nothing.
- R4: The enable bitmap of context c starts at offset 0x2000 + 0x80*c, with the same word and bit packing as the pending bitmap. Each context's enables are independent, and a source wakes a context only through that context's own enable bit.
- R5: The threshold of context c is at offset 0x200000 + 0x1000*c, and only bits [2:0] are kept. The claim/complete word of context c is at that offset + 4. Every other word in the context's 4 KiB region reads 0 and ignores writes.
- R6: irq_o[c] is high exactly when at least one source is pending, enabled for context c and has a priority strictly greater than that context's threshold. A source with priority 0 therefore never raises an interrupt.
- R7: A read of context c's claim word returns the ID of the most urgent eligible source, with ties going to the lowest ID, and clears that source's pending bit. When no source is eligible the read returns 0 and changes nothing.
- R8: A claimed source stays in flight until its ID is written to any claim/complete word. While it is in flight it cannot become pending. A completion write that carries an ID which is not in flight has no effect.
- R9: A source becomes pending on a rising edge of its input, and only if it is not in flight. A level that is still high when the completion arrives does not make the source pending again.
- R10: Read data appears on rdata_o in the cycle after the read request and holds until the next read. A read of an unmapped or misaligned address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Interrupt source levels; bit 0 is unused |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 26 | Byte address into the register map |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | NUM_CTX | Interrupt line per context |

## Verification
A claim read and a fresh rising edge of the same source can land in one clock edge. The claim removes the pending bit and marks the source in flight, so the rising edge must be lost. The bench provokes this by letting a pending source's level drop and then, at the same falling edge, raising it again while issuing the claim read. It then checks that the claim returns that source and that the pending bitmap no longer holds it. A later completion, made while the level is still high, must not bring the bit back.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int MAP_AW = 26;

  localparam logic [MAP_AW-1:0] PEND_BASE = 26'h000_1000;
  localparam logic [MAP_AW-1:0] PEND_END  = 26'h000_1080;
  localparam logic [MAP_AW-1:0] EN_BASE   = 26'h000_2000;
  localparam logic [MAP_AW-1:0] CTX_BASE  = 26'h020_0000;
  localparam int EN_STRIDE_LG = 7;
  localparam logic [13:0] CTX_PAGE0 = 14'h200;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_PRIO,
    RK_PEND,
    RK_EN,
    RK_THR,
    RK_CLAIM
  } reg_kind_e;
endpackage

// File: rtl/irq_gateway.sv
module irq_gateway #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] claim_oh_i,
  input  logic [NUM_SRC-1:0] done_oh_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] infl_o
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (s == 0) begin : g_rsvd
      logic unused_src0;
      assign unused_src0 = src_i[0] ^ claim_oh_i[0] ^ done_oh_i[0];
      assign pend_o[0] = 1'b0;
      assign infl_o[0] = 1'b0;
    end else begin : g_live
      logic lvl_q, pend_q, infl_q, rise;
      assign rise = src_i[s] & ~lvl_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          lvl_q  <= 1'b0;
          pend_q <= 1'b0;
          infl_q <= 1'b0;
        end else begin
          lvl_q  <= src_i[s];
          // a claim in the same cycle as an edge wins; the edge is lost
          pend_q <= ~claim_oh_i[s] & (pend_q | (rise & ~infl_q));
          infl_q <= (infl_q & ~done_oh_i[s]) | claim_oh_i[s];
        end
      end
      assign pend_o[s] = pend_q;
      assign infl_o[s] = infl_q;
    end
  end
endmodule

// File: rtl/irq_ctx_arb.sv
module irq_ctx_arb #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 5
) (
  input  logic [NUM_SRC-1:0]             pend_i,
  input  logic [NUM_SRC-1:0]             en_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]              thr_i,
  output logic [ID_W-1:0]                best_id_o,
  output logic                           irq_o
);
  logic [NUM_SRC-1:0] elig;
  logic [PRIO_W-1:0]  best_p;

  always_comb begin
    elig      = '0;
    best_p    = '0;
    best_id_o = '0;
    for (int s = 1; s < NUM_SRC; s++) begin
      elig[s] = pend_i[s] & en_i[s] & (prio_i[s] > thr_i);
      // strict compare keeps the lowest ID on ties
      if (elig[s] && (prio_i[s] > best_p)) begin
        best_p    = prio_i[s];
        best_id_o = ID_W'(s);
      end
    end
  end

  assign irq_o = |elig;
endmodule

// File: rtl/irq_reg_if.sv
module irq_reg_if
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 5
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_i,
  input  logic                           we_i,
  input  logic [MAP_AW-1:0]              addr_i,
  input  logic [31:0]                    wdata_i,
  output logic [31:0]                    rdata_o,
  input  logic [NUM_SRC-1:0]             pend_i,
  input  logic [NUM_CTX-1:0][ID_W-1:0]   best_id_i,
  output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_o,
  output logic [NUM_CTX-1:0][NUM_SRC-1:0] en_o,
  output logic [NUM_CTX-1:0][PRIO_W-1:0] thr_o,
  output logic [NUM_SRC-1:0]             claim_oh_o,
  output logic [NUM_SRC-1:0]             done_oh_o
);
  localparam int SRC_WORDS = (NUM_SRC + 31) / 32;
  localparam int PAD_W     = SRC_WORDS * 32;

  reg_kind_e   kind;
  logic [13:0] sel;
  logic [4:0]  word;
  logic        wr, rd;

  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_q;
  logic [NUM_CTX-1:0][NUM_SRC-1:0] en_q;
  logic [NUM_CTX-1:0][PRIO_W-1:0]  thr_q;
  logic [31:0] rd_d, rdata_q;
  logic [PAD_W-1:0] pend_pad;
  logic [PAD_W-1:0] en_pad [NUM_CTX];

  assign wr   = req_i & we_i;
  assign rd   = req_i & ~we_i;
  assign word = addr_i[6:2];

  // address decode
  always_comb begin
    kind = RK_NONE;
    sel  = '0;
    if (addr_i[1:0] == 2'b00) begin
      if (addr_i < PEND_BASE) begin
        sel = {4'b0, addr_i[11:2]};
        if (sel != '0 && int'(sel) < NUM_SRC) kind = RK_PRIO;
      end else if (addr_i < PEND_END) begin
        if (int'(word) < SRC_WORDS) kind = RK_PEND;
      end else if (addr_i >= EN_BASE && addr_i < CTX_BASE) begin
        sel = 14'((addr_i - EN_BASE) >> EN_STRIDE_LG);
        if (int'(sel) < NUM_CTX && int'(word) < SRC_WORDS) kind = RK_EN;
      end else if (addr_i >= CTX_BASE) begin
        sel = addr_i[25:12] - CTX_PAGE0;
        if (int'(sel) < NUM_CTX) begin
          if (addr_i[11:2] == 10'd0)      kind = RK_THR;
          else if (addr_i[11:2] == 10'd1) kind = RK_CLAIM;
        end
      end
    end
  end

  // configuration storage; source 0 entries never written
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (wr) begin
      case (kind)
        RK_PRIO: begin
          for (int s = 1; s < NUM_SRC; s++)
            if (int'(sel) == s) prio_q[s] <= wdata_i[PRIO_W-1:0];
        end
        RK_EN: begin
          for (int c = 0; c < NUM_CTX; c++)
            for (int s = 1; s < NUM_SRC; s++)
              if (int'(sel) == c && int'(word) == s / 32)
                en_q[c][s] <= wdata_i[s % 32];
        end
        RK_THR: begin
          for (int c = 0; c < NUM_CTX; c++)
            if (int'(sel) == c) thr_q[c] <= wdata_i[PRIO_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    pend_pad = '0;
    pend_pad[NUM_SRC-1:0] = pend_i;
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_en_pad
    always_comb begin
      en_pad[c] = '0;
      en_pad[c][NUM_SRC-1:0] = en_q[c];
    end
  end

  // read mux
  always_comb begin
    rd_d = '0;
    case (kind)
      RK_PRIO: begin
        for (int s = 1; s < NUM_SRC; s++)
          if (int'(sel) == s) rd_d = 32'(prio_q[s]);
      end
      RK_PEND: begin
        for (int k = 0; k < SRC_WORDS; k++)
          if (int'(word) == k) rd_d = pend_pad[k*32 +: 32];
      end
      RK_EN: begin
        for (int c = 0; c < NUM_CTX; c++)
          for (int k = 0; k < SRC_WORDS; k++)
            if (int'(sel) == c && int'(word) == k) rd_d = en_pad[c][k*32 +: 32];
      end
      RK_THR: begin
        for (int c = 0; c < NUM_CTX; c++)
          if (int'(sel) == c) rd_d = 32'(thr_q[c]);
      end
      RK_CLAIM: begin
        for (int c = 0; c < NUM_CTX; c++)
          if (int'(sel) == c) rd_d = 32'(best_id_i[c]);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_d;
  end

  // claim / complete strobes
  always_comb begin
    claim_oh_o = '0;
    done_oh_o  = '0;
    if (kind == RK_CLAIM) begin
      for (int c = 0; c < NUM_CTX; c++)
        for (int s = 1; s < NUM_SRC; s++)
          if (rd && int'(sel) == c && int'(best_id_i[c]) == s) claim_oh_o[s] = 1'b1;
      for (int s = 1; s < NUM_SRC; s++)
        if (wr && wdata_i == 32'(s)) done_oh_o[s] = 1'b1;
    end
  end

  assign rdata_o = rdata_q;
  assign prio_o  = prio_q;
  assign en_o    = en_q;
  assign thr_o   = thr_q;
endmodule

// File: rtl/irq_ctrl_core.sv
module irq_ctrl_core
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [MAP_AW-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic [NUM_CTX-1:0] irq_o
);
  localparam int ID_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0]              pend_w, infl_w, claim_oh_w, done_oh_w;
  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_w;
  logic [NUM_CTX-1:0][NUM_SRC-1:0] en_w;
  logic [NUM_CTX-1:0][PRIO_W-1:0]  thr_w;
  logic [NUM_CTX-1:0][ID_W-1:0]    best_id_w;

  irq_gateway #(.NUM_SRC(NUM_SRC)) u_gw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_i),
    .claim_oh_i (claim_oh_w),
    .done_oh_i  (done_oh_w),
    .pend_o     (pend_w),
    .infl_o     (infl_w)
  );

  irq_reg_if #(
    .NUM_SRC (NUM_SRC),
    .NUM_CTX (NUM_CTX),
    .PRIO_W  (PRIO_W),
    .ID_W    (ID_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .pend_i     (pend_w),
    .best_id_i  (best_id_w),
    .prio_o     (prio_w),
    .en_o       (en_w),
    .thr_o      (thr_w),
    .claim_oh_o (claim_oh_w),
    .done_oh_o  (done_oh_w)
  );

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    irq_ctx_arb #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .ID_W    (ID_W)
    ) u_arb (
      .pend_i    (pend_w),
      .en_i      (en_w[c]),
      .prio_i    (prio_w),
      .thr_i     (thr_w[c]),
      .best_id_o (best_id_w[c]),
      .irq_o     (irq_o[c])
    );
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_CTX-1:0] irq_o,
  input logic [NUM_SRC-1:0] pend_i,
  input logic [NUM_SRC-1:0] infl_i,
  input logic [NUM_SRC-1:0] claim_i
);
  a_r1_src0_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_i[0] && !infl_i[0]);

  a_r8_pend_infl_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i & infl_i) == '0);

  a_r6_irq_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> (|pend_i));

  a_r7_claim_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(claim_i));

  a_r7_claim_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|claim_i) |=> ((pend_i & $past(claim_i)) == '0));

  a_r8_claim_marks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|claim_i) |=> ((infl_i & $past(claim_i)) == $past(claim_i)));
endmodule

bind irq_ctrl_core irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_o   (irq_o),
  .pend_i  (pend_w),
  .infl_i  (infl_w),
  .claim_i (claim_oh_w)
);

// File: tb/irq_ctrl_core_tb_top.sv
module irq_ctrl_core_tb_top;
  localparam int NS = 32;
  localparam int NC = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NS-1:0] src_i = '0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [25:0]   addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NC-1:0] irq_o;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  irq_ctrl_core #(.NUM_SRC(NS), .NUM_CTX(NC), .PRIO_W(3)) dut_i (
    .clk_i, .rst_ni, .src_i, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .irq_o
  );

  typedef struct packed {
    logic        we;
    logic [25:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 26'h0000000, 32'h7,        32'h0,        8'd1},  // R1
    '{1'b0, 26'h0000000, 32'h0,        32'h0,        8'd1},  // R1
    '{1'b1, 26'h0000004, 32'hFF,       32'h0,        8'd2},  // R2
    '{1'b0, 26'h0000004, 32'h0,        32'h7,        8'd2},  // R2
    '{1'b1, 26'h000007C, 32'h3,        32'h0,        8'd2},  // R2
    '{1'b0, 26'h000007C, 32'h0,        32'h3,        8'd2},  // R2
    '{1'b0, 26'h0000080, 32'h0,        32'h0,        8'd10}, // R10
    '{1'b1, 26'h0001000, 32'hFFFFFFFF, 32'h0,        8'd3},  // R3
    '{1'b0, 26'h0001000, 32'h0,        32'h0,        8'd3},  // R3
    '{1'b1, 26'h0002000, 32'hFFFFFFFF, 32'h0,        8'd4},  // R4
    '{1'b0, 26'h0002000, 32'h0,        32'hFFFFFFFE, 8'd1},  // R1
    '{1'b0, 26'h0002080, 32'h0,        32'h0,        8'd4},  // R4
    '{1'b1, 26'h0002080, 32'hA,        32'h0,        8'd4},  // R4
    '{1'b0, 26'h0002080, 32'h0,        32'hA,        8'd4},  // R4
    '{1'b0, 26'h0002000, 32'h0,        32'hFFFFFFFE, 8'd4},  // R4
    '{1'b1, 26'h0200000, 32'h5,        32'h0,        8'd5},  // R5
    '{1'b0, 26'h0200000, 32'h0,        32'h5,        8'd5},  // R5
    '{1'b1, 26'h0201000, 32'hF,        32'h0,        8'd5},  // R5
    '{1'b0, 26'h0201000, 32'h0,        32'h7,        8'd5},  // R5
    '{1'b1, 26'h0200008, 32'h55,       32'h0,        8'd5},  // R5
    '{1'b0, 26'h0200008, 32'h0,        32'h0,        8'd5},  // R5
    '{1'b0, 26'h0003000, 32'h0,        32'h0,        8'd10}, // R10
    '{1'b0, 26'h0202000, 32'h0,        32'h0,        8'd10}, // R10
    '{1'b0, 26'h0000006, 32'h0,        32'h0,        8'd10}  // R10
  };

  localparam logic [25:0] PEND0  = 26'h0001000;
  localparam logic [25:0] THR0   = 26'h0200000;
  localparam logic [25:0] CLAIM0 = 26'h0200004;
  localparam logic [25:0] CLAIM1 = 26'h0201004;

  task automatic chk(input int tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic we, input logic [25:0] a, input logic [31:0] d,
                     output logic [31:0] rd);
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    rd = rdata_o;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic wr(input logic [25:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    bus(1'b1, a, d, dummy);
  endtask

  task automatic rd_chk(input int tag, input logic [25:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus(1'b0, a, 32'h0, v);
    chk(tag, v, exp);
  endtask

  task automatic set_src(input int idx, input logic v);
    @(negedge clk_i);
    src_i[idx] = v;
    @(negedge clk_i);
  endtask

  task automatic pulse_src(input int idx);
    set_src(idx, 1'b0);
    set_src(idx, 1'b1);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    // reset state: R10 / R6
    chk(10, rdata_o, 32'h0);
    chk(6, 32'(irq_o), 32'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(6, 32'(irq_o), 32'h0);

    // register map table
    for (int i = 0; i < NV; i++) begin
      bus(VECS[i].we, VECS[i].addr, VECS[i].wdata, v);
      if (!VECS[i].we) chk(int'(VECS[i].tag), v, VECS[i].exp);
    end

    // setup
    wr(THR0, 0);
    wr(26'h0201000, 0);
    wr(26'h000000C, 4);
    wr(26'h0000014, 4);

    // R9 edge latch, R6 priority 0 never interrupts, R7 empty claim
    set_src(9, 1'b1);
    rd_chk(9, PEND0, 32'h200);
    chk(6, 32'(irq_o), 32'h0);
    rd_chk(7, CLAIM0, 32'h0);
    rd_chk(7, PEND0, 32'h200);

    // R6 / R4: both contexts wake on src 3
    @(negedge clk_i); src_i[3] = 1'b1; src_i[5] = 1'b1;
    @(negedge clk_i);
    chk(6, 32'(irq_o), 32'h3);
    wr(THR0, 4);
    chk(6, 32'(irq_o), 32'h2);   // threshold equal to priority: no wake
    wr(THR0, 3);
    chk(6, 32'(irq_o), 32'h3);

    // R7: tie at priority 4 goes to the lower ID
    rd_chk(7, CLAIM0, 32'd3);
    rd_chk(7, PEND0, 32'h220);
    chk(4, 32'(irq_o), 32'h1);

    // R8: in-flight source ignores edges; completion of a non-claimed ID ignored
    pulse_src(3);
    rd_chk(8, PEND0, 32'h220);
    wr(CLAIM0, 5);
    rd_chk(8, PEND0, 32'h220);
    wr(CLAIM0, 3);
    rd_chk(9, PEND0, 32'h220);   // R9 level still high: no re-pend
    pulse_src(3);
    rd_chk(9, PEND0, 32'h228);

    // R7: higher priority beats lower ID; per-context claim
    wr(26'h0000014, 6);
    rd_chk(7, CLAIM0, 32'd5);
    rd_chk(7, PEND0, 32'h208);
    rd_chk(7, CLAIM1, 32'd3);
    rd_chk(7, PEND0, 32'h200);
    chk(6, 32'(irq_o), 32'h0);

    // R8: wrong-ID completion leaves src 5 in flight
    wr(CLAIM0, 6);
    pulse_src(5);
    rd_chk(8, PEND0, 32'h200);

    // R8 / R9: valid completion, then a fresh edge
    wr(CLAIM0, 5);
    rd_chk(9, PEND0, 32'h200);
    pulse_src(5);
    rd_chk(9, PEND0, 32'h220);

    // claim and rising edge of the same source in one cycle (R7, R8)
    set_src(5, 1'b0);
    @(negedge clk_i);
    src_i[5] = 1'b1;
    req_i = 1'b1; we_i = 1'b0; addr_i = CLAIM0;
    @(negedge clk_i);
    v = rdata_o;
    req_i = 1'b0;
    chk(7, v, 32'd5);
    rd_chk(8, PEND0, 32'h200);
    wr(CLAIM0, 5);
    rd_chk(9, PEND0, 32'h200);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule